// File: doc/BRIEF.md
# Reservation-Tracking Atomic Memory for Two Ports

This block is a small shared doubleword memory with two request ports. Its purpose is to let either port make a read-modify-write atomic without a lock. A port first issues a reserving load. The load returns the stored doubleword and marks that doubleword as reserved for the port. Later the port issues a conditional store. The conditional store writes only if no write from the other port has touched that doubleword since the reserving load. It returns a status word: zero on success, one on failure.

Plain loads and plain stores are also served. Every write from one port is watched by the other port's reservation tracker. Each accepted request gets a response exactly one cycle after the clock edge that accepts it. Port 0 is never held off. Port 1 is held off for one cycle only when both ports want to write the same doubleword in the same cycle. Port 0's write then lands first, and port 1's request is judged against the result.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no response is valid and no reservation is held, so a conditional store issued first fails with status 1.
- R2: Operation code 0 is a plain load and 1 is a plain store. A store writes the whole doubleword selected by address bits [ADDR_W-1:3] and returns data 0. A load returns that doubleword. The response of any accepted request appears one cycle after acceptance.
- R3: Operation code 2 is a reserving load and code 3 is a conditional store. A reserving load returns the doubleword. A conditional store that follows it from the same port, to the same doubleword and with no intervening write from the other port, writes its data and returns 0.
- R4: Suppose the other port writes any byte address inside the reserved doubleword between the reserving load and the conditional store. The conditional store then returns 1 and leaves memory unchanged.
- R5: A conditional store fails (returns 1, memory unchanged) if its port holds no reservation, or if its doubleword differs from the reserved one.
- R6: Every conditional store drops its own port's reservation, whether it succeeds or fails. A second conditional store without a new reserving load fails.
- R7: A new reserving load replaces the port's earlier reservation. A conditional store to the earlier doubleword then fails, and one to the new doubleword succeeds.
- R8: A plain store from the same port does not drop that port's own reservation.
- R9: When both ports request a write-type operation (store or conditional store) to the same doubleword in one cycle, port 1's ready is low. Port 0's write is applied first, and port 1 is accepted on the following cycle. A conditional store from port 1 in this case fails. A plain store from port 1 lands after port 0's and holds the final value. Writes to different doublewords proceed together.
- R10: A reserving load in the same cycle as a write from the other port to the same doubleword returns the value from before that write. It holds no reservation, so the next conditional store fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_req_valid | input | 1 | Port 0 request present |
| p0_req_ready | output | 1 | Port 0 request accepted (always high) |
| p0_req_op | input | 2 | Port 0 operation: 0 load, 1 store, 2 reserving load, 3 conditional store |
| p0_req_addr | input | ADDR_W | Port 0 byte address |
| p0_req_wdata | input | DATA_W | Port 0 write data |
| p0_rsp_valid | output | 1 | Port 0 response present |
| p0_rsp_data | output | DATA_W | Port 0 read data or status |
| p1_req_valid | input | 1 | Port 1 request present |
| p1_req_ready | output | 1 | Port 1 request accepted |
| p1_req_op | input | 2 | Port 1 operation, same coding as port 0 |
| p1_req_addr | input | ADDR_W | Port 1 byte address |
| p1_req_wdata | input | DATA_W | Port 1 write data |
| p1_rsp_valid | output | 1 | Port 1 response present |
| p1_rsp_data | output | DATA_W | Port 1 read data or status |

## Verification
Two cases are hard to reach from the ports: a same-cycle collision of write-type requests, and a reserving load that coincides with the other port's write. A sequence of single requests never produces either one. The stimulus therefore drives both ports on the same clock edge. It checks the combinational ready of port 1 before that edge, holds port 1's request until it is taken, and then reads the doubleword back to see which write landed last. The intervening-write case uses a byte address inside the reserved doubleword but different from the reserved address.

// File: rtl/lrsc_pkg.sv
// Package: shared operation coding for the reservation-tracking memory.
// Assumes a 2-bit operation field on every request port.
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_RESV  = 2'd2,
        OP_COND  = 2'd3
    } lrsc_op_e;
endpackage

// File: rtl/lrsc_mem_array.sv
// Module: lrsc_mem_array
// Doubleword storage with two combinational read ports and two write ports.
// Assumes the caller never writes the same index from both ports in one
// cycle. If it did, port 1 would be applied last.
module lrsc_mem_array #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx0,
    input  logic [IDX_W-1:0]  rd_idx1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    input  logic              we0,
    input  logic [IDX_W-1:0]  wi0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic [IDX_W-1:0]  wi1,
    input  logic [DATA_W-1:0] wd1
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Read the current contents (value before this cycle's writes).
    always_comb begin
        rd_data0 = mem[rd_idx0];
        rd_data1 = mem[rd_idx1];
    end

    // Apply port 0's write, then port 1's write.
    always_ff @(posedge clk) begin
        if (we0) mem[wi0] <= wd0;
        if (we1) mem[wi1] <= wd1;
    end
endmodule

// File: rtl/lrsc_resv_unit.sv
// Module: lrsc_resv_unit
// Holds one port's reservation (valid flag plus doubleword index). Judges
// that port's conditional stores. Assumes the peer write inputs carry only
// writes that actually change memory this cycle.
module lrsc_resv_unit
    import lrsc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  lrsc_op_e         op,
    input  logic [IDX_W-1:0] idx,
    input  logic             peer_wr_en,
    input  logic [IDX_W-1:0] peer_wr_idx,
    output logic             sc_pass
);
    logic             r_valid;
    logic [IDX_W-1:0] r_idx;
    logic             peer_hits_req;
    logic             peer_hits_resv;

    // Detect peer writes that collide with the request or the reservation.
    always_comb begin
        peer_hits_req  = peer_wr_en && (peer_wr_idx == idx);
        peer_hits_resv = peer_wr_en && (peer_wr_idx == r_idx);
    end

    // A conditional store passes only on a live reservation for its doubleword.
    always_comb sc_pass = fire && (op == OP_COND) && r_valid && (r_idx == idx);

    // Set, replace or drop the reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_valid <= 1'b0;
            r_idx   <= '0;
        end else if (fire && op == OP_RESV) begin
            r_valid <= !peer_hits_req;
            r_idx   <= idx;
        end else if (fire && op == OP_COND) begin
            r_valid <= 1'b0;
        end else if (peer_hits_resv) begin
            r_valid <= 1'b0;
        end
    end

    // R6
    sc_drops_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_COND) |=> !r_valid);

    // R4
    peer_write_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && peer_hits_resv && !(fire && op == OP_RESV)) |=> !r_valid);

    // R10
    resv_under_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_RESV && peer_hits_req) |=> !r_valid);
endmodule

// File: rtl/lrsc_rsp_stage.sv
// Module: lrsc_rsp_stage
// Registers one port's response. It returns read data for loads, 0 for plain
// stores, and a 0/1 status for conditional stores. Assumes rd_data is the
// value from before any write in the same cycle.
module lrsc_rsp_stage
    import lrsc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  lrsc_op_e          op,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              sc_pass,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic was_cond;

    // Capture the response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            was_cond  <= 1'b0;
        end else begin
            rsp_valid <= fire;
            was_cond  <= fire && (op == OP_COND);
            if (fire) begin
                unique case (op)
                    OP_LOAD, OP_RESV: rsp_data <= rd_data;
                    OP_COND:          rsp_data <= {{(DATA_W-1){1'b0}}, !sc_pass};
                    default:          rsp_data <= '0;
                endcase
            end
        end
    end

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);

    // R3
    status_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && was_cond) |-> (rsp_data[DATA_W-1:1] == '0));
endmodule

// File: rtl/lrsc_monitor.sv
// Module: lrsc_monitor (top)
// Two-port doubleword memory with reserving loads and conditional stores.
// Port 0 has priority. Port 1 is held off for one cycle when both ports
// request a write-type operation to the same doubleword. Assumes ADDR_W > 3.
// Address bits [2:0] are ignored.
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_req_valid,
    output logic              p0_req_ready,
    input  logic [1:0]        p0_req_op,
    input  logic [ADDR_W-1:0] p0_req_addr,
    input  logic [DATA_W-1:0] p0_req_wdata,
    output logic              p0_rsp_valid,
    output logic [DATA_W-1:0] p0_rsp_data,
    input  logic              p1_req_valid,
    output logic              p1_req_ready,
    input  logic [1:0]        p1_req_op,
    input  logic [ADDR_W-1:0] p1_req_addr,
    input  logic [DATA_W-1:0] p1_req_wdata,
    output logic              p1_rsp_valid,
    output logic [DATA_W-1:0] p1_rsp_data
);
    localparam int NPORT = 2;
    localparam int IDX_W = ADDR_W - 3;

    lrsc_op_e          op      [NPORT];
    logic [IDX_W-1:0]  idx     [NPORT];
    logic [DATA_W-1:0] wdata   [NPORT];
    logic [DATA_W-1:0] rd_data [NPORT];
    logic [DATA_W-1:0] rsp_d   [NPORT];
    logic [NPORT-1:0]  valid;
    logic [NPORT-1:0]  wr_type;
    logic [NPORT-1:0]  fire;
    logic [NPORT-1:0]  we;
    logic [NPORT-1:0]  sc_pass;
    logic [NPORT-1:0]  rsp_v;
    logic              clash;

    // Gather per-port request fields into arrays.
    always_comb begin
        valid[0] = p0_req_valid;
        valid[1] = p1_req_valid;
        op[0]    = lrsc_op_e'(p0_req_op);
        op[1]    = lrsc_op_e'(p1_req_op);
        idx[0]   = p0_req_addr[ADDR_W-1:3];
        idx[1]   = p1_req_addr[ADDR_W-1:3];
        wdata[0] = p0_req_wdata;
        wdata[1] = p1_req_wdata;
    end

    // Classify requests and hold port 1 on a same-doubleword write clash.
    always_comb begin
        for (int p = 0; p < NPORT; p++)
            wr_type[p] = valid[p] && (op[p] == OP_STORE || op[p] == OP_COND);
        clash        = wr_type[0] && wr_type[1] && (idx[0] == idx[1]);
        p0_req_ready = 1'b1;
        p1_req_ready = !clash;
        fire[0]      = valid[0];
        fire[1]      = valid[1] && !clash;
    end

    // Write enables: plain stores always write, conditional stores on pass.
    always_comb begin
        for (int p = 0; p < NPORT; p++)
            we[p] = fire[p] && (op[p] == OP_STORE || (op[p] == OP_COND && sc_pass[p]));
    end

    lrsc_mem_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
        .clk      (clk),
        .rd_idx0  (idx[0]),
        .rd_idx1  (idx[1]),
        .rd_data0 (rd_data[0]),
        .rd_data1 (rd_data[1]),
        .we0      (we[0]),
        .wi0      (idx[0]),
        .wd0      (wdata[0]),
        .we1      (we[1]),
        .wi1      (idx[1]),
        .wd1      (wdata[1])
    );

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        lrsc_resv_unit #(.IDX_W(IDX_W)) u_resv (
            .clk         (clk),
            .rst_n       (rst_n),
            .fire        (fire[gp]),
            .op          (op[gp]),
            .idx         (idx[gp]),
            .peer_wr_en  (we[NPORT-1-gp]),
            .peer_wr_idx (idx[NPORT-1-gp]),
            .sc_pass     (sc_pass[gp])
        );

        lrsc_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire      (fire[gp]),
            .op        (op[gp]),
            .rd_data   (rd_data[gp]),
            .sc_pass   (sc_pass[gp]),
            .rsp_valid (rsp_v[gp]),
            .rsp_data  (rsp_d[gp])
        );
    end

    // Drive the response ports.
    always_comb begin
        p0_rsp_valid = rsp_v[0];
        p0_rsp_data  = rsp_d[0];
        p1_rsp_valid = rsp_v[1];
        p1_rsp_data  = rsp_d[1];
    end

    // R9
    no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we[0] && we[1] && idx[0] == idx[1]));

    // R4
    p1_pass_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass[1] |-> !(we[0] && idx[0] == idx[1]));

    // R4
    p0_pass_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass[0] |-> !(we[1] && idx[0] == idx[1]));

    // R9
    p0_never_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p0_req_valid |-> p0_req_ready);
endmodule

// File: tb/lrsc_monitor_bench.sv
// Scoreboard bench: driver tasks queue expected responses, a monitor pops them.
module lrsc_monitor_bench;
    localparam int AW = 9;
    localparam int DW = 64;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LR = 2'd2, SC = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          p0_req_valid = 1'b0, p1_req_valid = 1'b0;
    logic          p0_req_ready, p1_req_ready;
    logic [1:0]    p0_req_op = '0, p1_req_op = '0;
    logic [AW-1:0] p0_req_addr = '0, p1_req_addr = '0;
    logic [DW-1:0] p0_req_wdata = '0, p1_req_wdata = '0;
    logic          p0_rsp_valid, p1_rsp_valid;
    logic [DW-1:0] p0_rsp_data, p1_rsp_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp0[$], exp1[$];
    string         tag0[$], tag1[$];

    always #5 clk = ~clk;

    lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) u_lrsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .p0_req_valid(p0_req_valid), .p0_req_ready(p0_req_ready), .p0_req_op(p0_req_op),
        .p0_req_addr(p0_req_addr), .p0_req_wdata(p0_req_wdata),
        .p0_rsp_valid(p0_rsp_valid), .p0_rsp_data(p0_rsp_data),
        .p1_req_valid(p1_req_valid), .p1_req_ready(p1_req_ready), .p1_req_op(p1_req_op),
        .p1_req_addr(p1_req_addr), .p1_req_wdata(p1_req_wdata),
        .p1_rsp_valid(p1_rsp_valid), .p1_rsp_data(p1_rsp_data)
    );

    task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, expv);
        end
    endtask

    task automatic set_port(input int port, input bit v, input logic [1:0] op,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (port == 0) begin
            p0_req_valid = v; p0_req_op = op; p0_req_addr = a; p0_req_wdata = d;
        end else begin
            p1_req_valid = v; p1_req_op = op; p1_req_addr = a; p1_req_wdata = d;
        end
    endtask

    task automatic push(input int port, input logic [DW-1:0] e, input string t);
        if (port == 0) begin exp0.push_back(e); tag0.push_back(t); end
        else begin exp1.push_back(e); tag1.push_back(t); end
    endtask

    // One request on one port; called at a falling edge.
    task automatic do1(input int port, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] e, input string t);
        set_port(port, 1'b1, op, a, d);
        push(port, e, t);
        @(posedge clk);
        @(negedge clk);
        set_port(port, 1'b0, LD, '0, '0);
    endtask

    // Requests on both ports in the same cycle; port 1 may be held one cycle.
    task automatic do2(input logic [1:0] op0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input logic [DW-1:0] e0,
                       input logic [1:0] op1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                       input logic [DW-1:0] e1, input bit held, input string t);
        set_port(0, 1'b1, op0, a0, d0);
        set_port(1, 1'b1, op1, a1, d1);
        push(0, e0, t);
        push(1, e1, t);
        #1;
        check(p1_req_ready == !held, {t, " port1 ready"}, {63'b0, p1_req_ready}, {63'b0, !held});
        @(posedge clk);
        @(negedge clk);
        set_port(0, 1'b0, LD, '0, '0);
        if (held) begin
            @(posedge clk);
            @(negedge clk);
        end
        set_port(1, 1'b0, LD, '0, '0);
    endtask

    // Monitor: compare every response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && p0_rsp_valid) begin
            if (exp0.size() == 0) check(1'b0, "R2 unexpected port0 response", p0_rsp_data, '0);
            else begin
                automatic logic [DW-1:0] e = exp0.pop_front();
                automatic string t = tag0.pop_front();
                check(p0_rsp_data === e, {t, " port0"}, p0_rsp_data, e);
            end
        end
        if (rst_n && p1_rsp_valid) begin
            if (exp1.size() == 0) check(1'b0, "R2 unexpected port1 response", p1_rsp_data, '0);
            else begin
                automatic logic [DW-1:0] e = exp1.pop_front();
                automatic string t = tag1.pop_front();
                check(p1_rsp_data === e, {t, " port1"}, p1_rsp_data, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(p0_rsp_valid == 1'b0 && p1_rsp_valid == 1'b0, "R1 no response after reset",
              {62'b0, p0_rsp_valid, p1_rsp_valid}, '0);
        do1(0, SC, 9'h010, 64'hDEAD, 64'd1, "R1 cond store after reset");

        // R2 plain stores and loads across ports
        do1(0, ST, 9'h000, 64'hA0A0_0000_0000_000A, 64'd0, "R2 store");
        do1(1, LD, 9'h000, '0, 64'hA0A0_0000_0000_000A, "R2 load");
        do1(1, ST, 9'h008, 64'hB, 64'd0, "R2 store");
        do1(0, LD, 9'h00B, '0, 64'hB, "R2 load low bits ignored");

        // R3 successful reserve/conditional pair
        do1(0, LR, 9'h000, '0, 64'hA0A0_0000_0000_000A, "R3 reserve");
        do1(0, SC, 9'h000, 64'hC, 64'd0, "R3 cond pass");
        do1(1, LD, 9'h000, '0, 64'hC, "R3 written");

        // R4 peer write inside doubleword breaks reservation
        do1(0, LR, 9'h008, '0, 64'hB, "R4 reserve");
        do1(1, ST, 9'h00C, 64'hD, 64'd0, "R4 peer store");
        do1(0, SC, 9'h008, 64'hE, 64'd1, "R4 cond fail");
        do1(0, LD, 9'h008, '0, 64'hD, "R4 memory unchanged");

        // R5 no reservation / other doubleword
        do1(1, SC, 9'h000, 64'h99, 64'd1, "R5 no reservation");
        do1(1, LR, 9'h000, '0, 64'hC, "R5 reserve");
        do1(1, SC, 9'h008, 64'h98, 64'd1, "R5 other doubleword");
        do1(1, LD, 9'h008, '0, 64'hD, "R5 memory unchanged");

        // R6 every conditional store drops the reservation
        do1(1, SC, 9'h000, 64'h97, 64'd1, "R6 after failed cond");
        do1(1, LR, 9'h000, '0, 64'hC, "R6 reserve");
        do1(1, SC, 9'h000, 64'hF, 64'd0, "R6 first cond");
        do1(1, SC, 9'h000, 64'h96, 64'd1, "R6 second cond");
        do1(1, LD, 9'h000, '0, 64'hF, "R6 memory");

        // R7 new reservation replaces the old one
        do1(0, ST, 9'h010, 64'h10, 64'd0, "R7 setup");
        do1(0, ST, 9'h018, 64'h18, 64'd0, "R7 setup");
        do1(0, LR, 9'h010, '0, 64'h10, "R7 reserve a");
        do1(0, LR, 9'h018, '0, 64'h18, "R7 reserve b");
        do1(0, SC, 9'h010, 64'h95, 64'd1, "R7 cond old fails");
        do1(0, LD, 9'h010, '0, 64'h10, "R7 memory");
        do1(0, LR, 9'h010, '0, 64'h10, "R7 reserve a again");
        do1(0, LR, 9'h018, '0, 64'h18, "R7 reserve b again");
        do1(0, SC, 9'h018, 64'h1B, 64'd0, "R7 cond new passes");

        // R8 own plain store keeps own reservation
        do1(0, ST, 9'h020, 64'h20, 64'd0, "R8 setup");
        do1(0, LR, 9'h020, '0, 64'h20, "R8 reserve");
        do1(0, ST, 9'h020, 64'h21, 64'd0, "R8 own store");
        do1(0, SC, 9'h020, 64'h22, 64'd0, "R8 cond passes");
        do1(1, LD, 9'h020, '0, 64'h22, "R8 memory");

        // R9 same-doubleword write clash
        do1(1, ST, 9'h028, 64'h28, 64'd0, "R9 setup");
        do1(1, LR, 9'h028, '0, 64'h28, "R9 reserve p1");
        do2(ST, 9'h028, 64'h2A, 64'd0, SC, 9'h02C, 64'h2B, 64'd1, 1'b1, "R9 store vs cond");
        do1(0, LD, 9'h028, '0, 64'h2A, "R9 port0 landed");
        do2(ST, 9'h030, 64'h30, 64'd0, ST, 9'h030, 64'h31, 64'd0, 1'b1, "R9 store vs store");
        do1(0, LD, 9'h030, '0, 64'h31, "R9 port1 last");
        do2(ST, 9'h038, 64'h38, 64'd0, ST, 9'h040, 64'h40, 64'd0, 1'b0, "R9 distinct");
        do1(1, LD, 9'h038, '0, 64'h38, "R9 distinct a");
        do1(0, LD, 9'h040, '0, 64'h40, "R9 distinct b");

        // R10 reserving load under a same-cycle peer write
        do1(0, ST, 9'h048, 64'h48, 64'd0, "R10 setup");
        do2(LR, 9'h048, '0, 64'h48, ST, 9'h048, 64'h49, 64'd0, 1'b0, "R10 reserve under write");
        do1(0, SC, 9'h048, 64'h4A, 64'd1, "R10 cond fails");
        do1(1, LD, 9'h048, '0, 64'h49, "R10 memory");

        repeat (3) @(negedge clk);
        check(exp0.size() == 0 && exp1.size() == 0, "R2 all responses seen",
              64'(exp0.size() + exp1.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule